// File: doc/BRIEF.md
# Slot Register Interrupt Block for an AC'97 Link

This block holds the command, status and GPIO slot words that software writes for an AC'97 link, and the slot 2 word that the link returns. It reports, per slot, whether everything written has left on the link, and whether a fresh slot 2 word is waiting to be read. The flags clear as a side effect of using the data registers. A write to a slot register clears that slot's transmit-complete flag. A read of the slot 2 register clears the receive flag. There is no separate acknowledge register.

Each of the three transmit registers offers its word to the frame engine on a valid/ready pair. Valid rises on the cycle after a write. Valid and the word then stay stable until the engine raises ready, and the word counts as sent on that edge. The engine may hold ready low for as long as it needs. Received slot 2 words arrive as a one-cycle strobe with no back-pressure: a word that arrives before the last one was read overwrites it. A control register holds a loopback bit, which steers the engine's serial output back into its serial input, and the four interrupt enables.

Top module: `slot_reg_irq`

## Requirements
- R1: After reset, tx_valid is 000, irq_raw is 0111, the control register (loopback and enables) is 0, irq_masked is 0000 and irq is 0.
- R2: A write with wr_sel = 0 (slot 1), 1 (slot 2) or 2 (slot 12) stores wr_data. The word appears on that slot's lane of tx_data (lane i at bits [20*i+19:20*i]) and that slot's tx_valid bit is 1 from the next cycle. A write made while the slot is still pending replaces the word.
- R3: While tx_valid[i] is 1 and tx_ready[i] is 0, and no write to slot i occurs, tx_valid[i] and the lane stay unchanged. An edge with tx_valid[i] and tx_ready[i] both 1 and no write drops tx_valid[i] in the next cycle.
- R4: irq_raw bit i (0 = slot 1, 1 = slot 2, 2 = slot 12) is the transmit-complete flag, equal to 1 exactly when slot i has no word pending. When a write and an acceptance fall on the same edge, the write wins: valid stays 1 with the new word and the flag stays 0.
- R5: A cycle with rx_valid = 1 captures rx_data into the receive register. A read with rd_sel = 1 returns that word on rd_data.
- R6: irq_raw bit 3 (receive flag) is set by rx_valid. It is cleared by an edge with rd_en = 1 and rd_sel = 1 and no rx_valid. If both occur on the same edge, the new word is kept and the flag stays 1.
- R7: Reads with rd_sel = 0 or 2 return the last word written to slot 1 or slot 12. These reads and any read with rd_en = 0 leave the receive flag unchanged.
- R8: A write with wr_sel = 3 loads wr_data[4:0] into the control register: bit 0 is loopback, and bits 4:1 enable irq_raw bits 3:0. A read with rd_sel = 3 returns it zero-extended.
- R9: ser_in equals ser_out when loopback is 1 and ser_pin_in when loopback is 0.
- R10: irq_masked is irq_raw ANDed bitwise with the enables. irq is 1 exactly when any irq_masked bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 slot 1, 1 slot 2, 2 slot 12, 3 control |
| wr_data | input | 20 | Write data |
| rd_en | input | 1 | Register read strobe (side effect on slot 2 only) |
| rd_sel | input | 2 | Read target, same coding as wr_sel |
| rd_data | output | 20 | Read data, combinational from rd_sel |
| tx_valid | output | 3 | Per-slot word pending toward the frame engine |
| tx_ready | input | 3 | Per-slot acceptance from the frame engine |
| tx_data | output | 60 | Three 20-bit slot words, slot index i at lane i |
| rx_valid | input | 1 | Strobe: a slot 2 word was received |
| rx_data | input | 20 | Received slot 2 word |
| ser_out | input | 1 | Serial output stream from the frame engine |
| ser_pin_in | input | 1 | Serial input from the link pin |
| ser_in | output | 1 | Serial input to the frame engine |
| irq_raw | output | 4 | Raw flags: 0..2 transmit complete, 3 slot 2 received |
| irq_masked | output | 4 | Raw flags gated by their enables |
| irq | output | 1 | OR of the masked flags |

## Verification
The bench goes after same-edge collisions. A write meeting an acceptance must leave the flag low; a design that let the acceptance win would report a word as sent that never left. A receive strobe meeting a read must keep the flag set; a design that cleared it would lose the new word without notice. The bench also checks that held-off words stay stable under back-pressure, since a design that dropped valid early would skip a slot. It checks that reads of other registers do not clear the receive flag, since a design with a loose address decode would. Long mixed sweeps drive every write target, ready pattern, read target and loopback setting against a model built from the rules above.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int NSLOT = 3;
  localparam int NIRQ  = NSLOT + 1;
  localparam int CW    = NIRQ + 1;

  typedef enum logic [1:0] {
    SEL_S1   = 2'd0,
    SEL_S2   = 2'd1,
    SEL_S12  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/slot_tx_buf.sv
module slot_tx_buf #(
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          done
);
  logic          pending;
  logic [DW-1:0] word;

  // A write overrides an acceptance on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      word    <= '0;
    end else if (load) begin
      pending <= 1'b1;
      word    <= load_data;
    end else if (pending && ready) begin
      pending <= 1'b0;
    end
  end

  assign valid = pending;
  assign data  = word;
  assign done  = ~pending;

  a_r2_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (valid && data == $past(load_data)));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data)));
  a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> done);
  a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && load) |=> (valid && !done));
endmodule

// File: rtl/slot_rx_buf.sv
module slot_rx_buf #(
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          rd_clr,
  output logic [DW-1:0] word,
  output logic          flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
      flag <= 1'b0;
    end else if (in_valid) begin
      word <= in_data;
      flag <= 1'b1;
    end else if (rd_clr) begin
      flag <= 1'b0;
    end
  end

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (flag && word == $past(in_data)));
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !in_valid) |=> !flag);
  a_r6_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && in_valid) |=> flag);
endmodule

// File: rtl/slot_irq_ctrl.sv
module slot_irq_ctrl
  import slot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic [CW-1:0]   ctrl_wdata,
  output logic [CW-1:0]   ctrl_q,
  input  logic [NIRQ-1:0] raw,
  output logic [NIRQ-1:0] masked,
  output logic            irq,
  input  logic            ser_out,
  input  logic            ser_pin_in,
  output logic            ser_in
);
  logic            loop_on;
  logic [NIRQ-1:0] enables;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;
  end

  assign loop_on = ctrl_q[0];
  assign enables = ctrl_q[CW-1:1];
  assign masked  = raw & enables;
  assign irq     = |masked;
  assign ser_in  = loop_on ? ser_out : ser_pin_in;

  a_r8_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q == $past(ctrl_wdata)));
  a_r8_ctrl_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));
endmodule

// File: rtl/slot_reg_irq.sv
module slot_reg_irq
  import slot_pkg::*;
#(
  parameter int DW = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [DW-1:0]       wr_data,
  input  logic                rd_en,
  input  logic [1:0]          rd_sel,
  output logic [DW-1:0]       rd_data,
  output logic [NSLOT-1:0]    tx_valid,
  input  logic [NSLOT-1:0]    tx_ready,
  output logic [NSLOT*DW-1:0] tx_data,
  input  logic                rx_valid,
  input  logic [DW-1:0]       rx_data,
  input  logic                ser_out,
  input  logic                ser_pin_in,
  output logic                ser_in,
  output logic [NIRQ-1:0]     irq_raw,
  output logic [NIRQ-1:0]     irq_masked,
  output logic                irq
);
  logic [NSLOT-1:0] tx_done;
  logic [DW-1:0]    rx_word;
  logic             rx_flag;
  logic [CW-1:0]    ctrl_q;

  for (genvar i = 0; i < NSLOT; i++) begin : g_tx
    slot_tx_buf #(.DW(DW)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_en && (wr_sel == 2'(i))),
      .load_data (wr_data),
      .ready     (tx_ready[i]),
      .valid     (tx_valid[i]),
      .data      (tx_data[i*DW +: DW]),
      .done      (tx_done[i])
    );
  end

  slot_rx_buf #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_valid),
    .in_data  (rx_data),
    .rd_clr   (rd_en && (rd_sel == SEL_S2)),
    .word     (rx_word),
    .flag     (rx_flag)
  );

  assign irq_raw = {rx_flag, tx_done};

  slot_irq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (wr_en && (wr_sel == SEL_CTRL)),
    .ctrl_wdata (wr_data[CW-1:0]),
    .ctrl_q     (ctrl_q),
    .raw        (irq_raw),
    .masked     (irq_masked),
    .irq        (irq),
    .ser_out    (ser_out),
    .ser_pin_in (ser_pin_in),
    .ser_in     (ser_in)
  );

  always_comb begin
    case (rd_sel)
      SEL_S1:  rd_data = tx_data[0 +: DW];
      SEL_S2:  rd_data = rx_word;
      SEL_S12: rd_data = tx_data[2*DW +: DW];
      default: rd_data = {{(DW-CW){1'b0}}, ctrl_q};
    endcase
  end

  a_r7_other_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !(rd_en && rd_sel == SEL_S2)) |=> $stable(irq_raw[NIRQ-1]));
endmodule

// File: tb/slot_reg_irq_tb.sv
`timescale 1ns/1ps
module slot_reg_irq_tb;
  localparam int DW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, rx_valid = 1'b0;
  logic [1:0]    wr_sel = '0, rd_sel = '0;
  logic [DW-1:0] wr_data = '0, rx_data = '0, rd_data;
  logic [2:0]    tx_valid, tx_ready = '0;
  logic [3*DW-1:0] tx_data;
  logic          ser_out = 1'b0, ser_pin_in = 1'b0, ser_in;
  logic [3:0]    irq_raw, irq_masked;
  logic          irq;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // Reference state built from the requirements
  logic [2:0]    m_pend;
  logic [DW-1:0] m_word [3];
  logic          m_rxf;
  logic [DW-1:0] m_rxw;
  logic [4:0]    m_ctrl;
  logic [31:0]   seed = 32'h1234_5678;

  always #4 clk = ~clk;

  slot_reg_irq #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .ser_out(ser_out), .ser_pin_in(ser_pin_in), .ser_in(ser_in),
    .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  // Compare every output against the reference state
  task automatic check_all();
    logic [3:0]    exp_raw;
    logic [DW-1:0] exp_rd;
    exp_raw = {m_rxf, ~m_pend};
    chk("R3 tx_valid", 64'(tx_valid), 64'(m_pend));
    for (int i = 0; i < 3; i++)
      chk("R2 tx lane", 64'(tx_data[i*DW +: DW]), 64'(m_word[i]));
    chk("R4 tx complete flags", 64'(irq_raw[2:0]), 64'(exp_raw[2:0]));
    chk("R6 rx flag", 64'(irq_raw[3]), 64'(m_rxf));
    case (rd_sel)
      2'd0: exp_rd = m_word[0];
      2'd1: exp_rd = m_rxw;
      2'd2: exp_rd = m_word[2];
      default: exp_rd = {{(DW-5){1'b0}}, m_ctrl};
    endcase
    if (rd_sel == 2'd1) chk("R5 rx readback", 64'(rd_data), 64'(exp_rd));
    else if (rd_sel == 2'd3) chk("R8 ctrl readback", 64'(rd_data), 64'(exp_rd));
    else chk("R7 tx readback", 64'(rd_data), 64'(exp_rd));
    chk("R9 ser_in", 64'(ser_in), 64'(m_ctrl[0] ? ser_out : ser_pin_in));
    chk("R10 masked", 64'(irq_masked), 64'(exp_raw & m_ctrl[4:1]));
    chk("R10 irq", 64'(irq), 64'(|(exp_raw & m_ctrl[4:1])));
  endtask

  // Advance the reference state by one edge using the current inputs
  task automatic model_step();
    for (int i = 0; i < 3; i++) begin
      if (wr_en && wr_sel == 2'(i)) begin
        m_pend[i] = 1'b1;
        m_word[i] = wr_data;
      end else if (m_pend[i] && tx_ready[i]) begin
        m_pend[i] = 1'b0;
      end
    end
    if (wr_en && wr_sel == 2'd3) m_ctrl = wr_data[4:0];
    if (rx_valid) begin
      m_rxf = 1'b1;
      m_rxw = rx_data;
    end else if (rd_en && rd_sel == 2'd1) begin
      m_rxf = 1'b0;
    end
  endtask

  task automatic cyc();
    #1;
    check_all();
    model_step();
    @(negedge clk);
  endtask

  initial begin
    m_pend = '0; m_rxf = 1'b0; m_rxw = '0; m_ctrl = '0;
    for (int i = 0; i < 3; i++) m_word[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 tx_valid", 64'(tx_valid), 64'h0);
    chk("R1 irq_raw", 64'(irq_raw), 64'h7);
    chk("R1 masked", 64'(irq_masked), 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
    rd_sel = 2'd3; #1;
    chk("R1 ctrl", 64'(rd_data), 64'h0);

    // R4: write to slot 1 while its pending word is accepted
    wr_en = 1; wr_sel = 0; wr_data = 20'h11111; cyc();
    wr_data = 20'h22222; tx_ready = 3'b001; cyc();
    wr_en = 0; tx_ready = 0; #1;
    chk("R4 write wins valid", 64'(tx_valid[0]), 64'h1);
    chk("R4 write wins word", 64'(tx_data[DW-1:0]), 64'h22222);
    cyc();
    // R3: back-pressure holds, then acceptance clears
    cyc(); cyc();
    tx_ready = 3'b001; cyc();
    tx_ready = 0; #1;
    chk("R3 accepted", 64'(irq_raw[0]), 64'h1);
    // R6: receive and read on the same edge
    rx_valid = 1; rx_data = 20'hABCDE; cyc();
    rx_data = 20'h13579; rd_en = 1; rd_sel = 1; cyc();
    rx_valid = 0; #1;
    chk("R6 collision keeps flag", 64'(irq_raw[3]), 64'h1);
    chk("R5 new word", 64'(rd_data), 64'h13579);
    // R7: other reads leave the flag; R6: slot 2 read clears it
    rd_sel = 0; cyc(); rd_sel = 2; cyc();
    #1; chk("R7 flag kept", 64'(irq_raw[3]), 64'h1);
    rd_sel = 1; cyc();
    rd_en = 0; #1;
    chk("R6 read clears", 64'(irq_raw[3]), 64'h0);

    // Mixed sweep over all targets, ready patterns, reads and loopback
    for (int k = 0; k < 6000; k++) begin
      seed = nxt(seed);
      wr_en      = (seed[31:30] == 2'b00);
      wr_sel     = seed[29:28];
      wr_data    = {seed[27:16], seed[15:8]};
      rd_en      = seed[7];
      rd_sel     = seed[6:5];
      tx_ready   = seed[4:2];
      seed = nxt(seed);
      rx_valid   = (seed[31:30] == 2'b01);
      rx_data    = seed[29:10];
      ser_out    = seed[9];
      ser_pin_in = seed[8];
      cyc();
    end
    wr_en = 0; rd_en = 0; rx_valid = 0; tx_ready = 0;
    #1; check_all();

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule